// File: doc/BRIEF.md
# Selector-Triggered Segment Descriptor Cache Loader

This block holds a visible 16-bit segment selector together with a hidden 48-bit cache of the segment's base and limit. A write to the selector starts a hardware walk of the global descriptor table. The block reads the 8-byte descriptor as two 32-bit words through a simple memory read port and fills the cache from them. The selector and the cache change together, at the moment the walk completes. It serves a local-table register or a task register, where the processor must not read the table in memory on every access.

The table base and limit come in on a 48-bit input. The limit sits in the low 16 bits and the base in the upper 32. Both are sampled when the write is accepted. Before reading memory, the block checks that the whole descriptor lies inside the table. A descriptor that would run past the table limit raises a one-cycle fault. A faulting load performs no reads and leaves the selector, the cache and the valid flag as they were.

The controller is a state machine with these states:
- `LD_IDLE`: waits for a write.
- `LD_CHECK`: runs the bounds test.
- `LD_REQ_LO` and `LD_WAIT_LO`: read and capture the first descriptor word.
- `LD_REQ_HI` and `LD_WAIT_HI`: read and capture the second word.
- `LD_COMMIT`: updates the visible registers.
- `LD_FAULT`: signals a rejected load.

The transitions are:
- IDLE to CHECK on an accepted write.
- CHECK to FAULT when the descriptor is out of range, otherwise CHECK to REQ_LO.
- REQ_LO to WAIT_LO, unconditionally.
- WAIT_LO to REQ_HI when read data is valid.
- REQ_HI to WAIT_HI, unconditionally.
- WAIT_HI to COMMIT when read data is valid.
- COMMIT to IDLE and FAULT to IDLE, unconditionally.

Top module: `seg_cache_loader`

## Requirements
- R1: After reset, `sel_o` is 0, `cache_o` is 0, and `cache_valid_o`, `busy_o`, `fault_o` and `mem_rd_en_o` are all 0.
- R2: A write (`sel_wr_en_i` high) sampled while `busy_o` is low is accepted. `busy_o` is high in the next cycle and stays high until the load ends. `busy_o` never rises without an accepted write.
- R3: The index is selector bits [15:3]. The first descriptor word is read from table base + index×8 and the second from table base + index×8 + 4. Selector bits [2:0] do not affect the addresses. The table base and limit are those present on `gdtr_i` in the cycle the write is accepted.
- R4: The limit is bits [15:0] of the first word; bits [31:16] of that word are ignored. The base is all 32 bits of the second word. The cache is {base, limit}, so base 00002100h and limit 001Fh give 00002100001Fh.
- R5: On a successful load, `sel_o` takes the written selector and `cache_o` takes the new value. `cache_valid_o` becomes 1 in the same cycle that `busy_o` falls, and the cache changes at no other time.
- R6: A write sampled while `busy_o` is high is ignored. It causes no extra reads and does not change the selector or cache that the running load produces.
- R7: If index×8 + 7 exceeds the table limit, no memory read is issued. `fault_o` is high for exactly one cycle, `busy_o` then falls, and `sel_o`, `cache_o` and `cache_valid_o` keep their previous values (including 0 before any load).
- R8: A descriptor whose last byte sits exactly at the table limit (index×8 + 7 equal to the limit) loads normally. This holds for the highest index, 1FFFh, with a limit of FFFFh.
- R9: `mem_rd_en_o` is a one-cycle pulse per word and appears only while `busy_o` is high. At most one read is outstanding, and the block waits any number of cycles for `mem_rd_valid_i`.
- R10: Writing the same selector value again performs a full new walk and picks up changed descriptor contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr_en_i | input | 1 | Selector write strobe |
| sel_wr_data_i | input | 16 | New selector value |
| gdtr_i | input | 48 | Table base [47:16] and limit [15:0] |
| mem_rd_en_o | output | 1 | Descriptor word read request |
| mem_rd_addr_o | output | 32 | Byte address of the requested word |
| mem_rd_valid_i | input | 1 | Read data valid |
| mem_rd_data_i | input | 32 | Read data word |
| sel_o | output | 16 | Visible selector |
| cache_o | output | 48 | Cached base [47:16] and limit [15:0] |
| cache_valid_o | output | 1 | Cache holds a successfully loaded descriptor |
| busy_o | output | 1 | A load is in progress |
| fault_o | output | 1 | One-cycle pulse when a load is rejected |

## Verification
Selectors with the same index but different low flag bits confirm that only bits [15:3] steer the address. Read latencies of 1, 3 and 5 cycles separate a correct wait on the valid strobe from a fixed-delay assumption. Pairs of selectors on either side of the table limit, including the highest index against the largest limit, tell an off-by-one in the bounds test from a correct one. A second write during a load, a change of `gdtr_i` mid-load, a repeat of the same selector after the memory changes, and a fault before any load each tell a correctly latched, retriggering design from one that merely follows its inputs.

// File: rtl/segld_pkg.sv
package segld_pkg;

    localparam int unsigned DESC_BYTES = 8;
    localparam int unsigned DESC_SHIFT = $clog2(DESC_BYTES);
    localparam int unsigned WORD_BYTES = 4;

    typedef enum logic [2:0] {
        LD_IDLE,
        LD_CHECK,
        LD_REQ_LO,
        LD_WAIT_LO,
        LD_REQ_HI,
        LD_WAIT_HI,
        LD_COMMIT,
        LD_FAULT
    } ld_state_e;

    typedef struct packed {
        logic accept;
        logic busy;
        logic rd_en;
        logic rd_hi;
        logic cap_lo;
        logic cap_hi;
        logic commit;
        logic fault;
    } ld_ctl_t;

endpackage

// File: rtl/segld_bounds.sv
module segld_bounds #(
    parameter int unsigned IDX_W  = 13,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LIM_W  = 16
) (
    input  logic [IDX_W-1:0]  index_i,
    input  logic [ADDR_W-1:0] tbl_base_i,
    input  logic [LIM_W-1:0]  tbl_lim_i,
    output logic [ADDR_W-1:0] lo_addr_o,
    output logic [ADDR_W-1:0] hi_addr_o,
    output logic              out_of_range_o
);
    import segld_pkg::*;

    localparam int unsigned OFF_W = IDX_W + DESC_SHIFT;
    localparam int unsigned CMP_W = ((OFF_W > LIM_W) ? OFF_W : LIM_W) + 1;

    logic [OFF_W-1:0] byte_off;
    logic [CMP_W-1:0] last_byte;

    always_comb begin
        byte_off       = {index_i, {DESC_SHIFT{1'b0}}};
        last_byte      = CMP_W'(byte_off) + CMP_W'(DESC_BYTES - 1);
        out_of_range_o = last_byte > CMP_W'(tbl_lim_i);
        lo_addr_o      = tbl_base_i + ADDR_W'(byte_off);
        hi_addr_o      = lo_addr_o + ADDR_W'(WORD_BYTES);
    end

endmodule

// File: rtl/segld_fsm.sv
module segld_fsm (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req_i,
    input  logic               range_fault_i,
    input  logic               rd_valid_i,
    output segld_pkg::ld_ctl_t ctl_o
);
    import segld_pkg::*;

    ld_state_e state_q;
    ld_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:    if (wr_req_i) state_d = LD_CHECK;
            LD_CHECK:   state_d = range_fault_i ? LD_FAULT : LD_REQ_LO;
            LD_REQ_LO:  state_d = LD_WAIT_LO;
            LD_WAIT_LO: if (rd_valid_i) state_d = LD_REQ_HI;
            LD_REQ_HI:  state_d = LD_WAIT_HI;
            LD_WAIT_HI: if (rd_valid_i) state_d = LD_COMMIT;
            LD_COMMIT:  state_d = LD_IDLE;
            LD_FAULT:   state_d = LD_IDLE;
            default:    state_d = LD_IDLE;
        endcase
    end

    always_comb begin
        ctl_o      = '0;
        ctl_o.busy = (state_q != LD_IDLE);
        unique case (state_q)
            LD_IDLE:    ctl_o.accept = wr_req_i;
            LD_CHECK:   ;
            LD_REQ_LO:  ctl_o.rd_en  = 1'b1;
            LD_WAIT_LO: ctl_o.cap_lo = rd_valid_i;
            LD_REQ_HI: begin
                ctl_o.rd_en = 1'b1;
                ctl_o.rd_hi = 1'b1;
            end
            LD_WAIT_HI: begin
                ctl_o.rd_hi  = 1'b1;
                ctl_o.cap_hi = rd_valid_i;
            end
            LD_COMMIT:  ctl_o.commit = 1'b1;
            LD_FAULT:   ctl_o.fault  = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/segld_regs.sv
module segld_regs #(
    parameter int unsigned SEL_W  = 16,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LIM_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  segld_pkg::ld_ctl_t      ctl_i,
    input  logic [SEL_W-1:0]        wr_sel_i,
    input  logic [ADDR_W-1:0]       gdt_base_i,
    input  logic [LIM_W-1:0]        gdt_lim_i,
    input  logic [ADDR_W-1:0]       rd_data_i,
    output logic [SEL_W-1:0]        pend_sel_o,
    output logic [ADDR_W-1:0]       pend_base_o,
    output logic [LIM_W-1:0]        pend_lim_o,
    output logic [SEL_W-1:0]        sel_o,
    output logic [ADDR_W+LIM_W-1:0] cache_o,
    output logic                    valid_o
);
    logic [LIM_W-1:0]  stage_lim_q;
    logic [ADDR_W-1:0] stage_base_q;
    logic              unused_desc_bits;

    assign unused_desc_bits = ^rd_data_i[ADDR_W-1:LIM_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_sel_o  <= '0;
            pend_base_o <= '0;
            pend_lim_o  <= '0;
        end else if (ctl_i.accept) begin
            pend_sel_o  <= wr_sel_i;
            pend_base_o <= gdt_base_i;
            pend_lim_o  <= gdt_lim_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_lim_q  <= '0;
            stage_base_q <= '0;
        end else begin
            if (ctl_i.cap_lo) stage_lim_q  <= rd_data_i[LIM_W-1:0];
            if (ctl_i.cap_hi) stage_base_q <= rd_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_o   <= '0;
            cache_o <= '0;
            valid_o <= 1'b0;
        end else if (ctl_i.commit) begin
            sel_o   <= pend_sel_o;
            cache_o <= {stage_base_q, stage_lim_q};
            valid_o <= 1'b1;
        end
    end

endmodule

// File: rtl/seg_cache_loader.sv
module seg_cache_loader #(
    parameter int unsigned SEL_W  = 16,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LIM_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_wr_en_i,
    input  logic [SEL_W-1:0]        sel_wr_data_i,
    input  logic [ADDR_W+LIM_W-1:0] gdtr_i,
    output logic                    mem_rd_en_o,
    output logic [ADDR_W-1:0]       mem_rd_addr_o,
    input  logic                    mem_rd_valid_i,
    input  logic [ADDR_W-1:0]       mem_rd_data_i,
    output logic [SEL_W-1:0]        sel_o,
    output logic [ADDR_W+LIM_W-1:0] cache_o,
    output logic                    cache_valid_o,
    output logic                    busy_o,
    output logic                    fault_o
);
    import segld_pkg::*;

    localparam int unsigned IDX_W = SEL_W - DESC_SHIFT;

    ld_ctl_t           ctl;
    logic [SEL_W-1:0]  pend_sel;
    logic [ADDR_W-1:0] pend_base;
    logic [LIM_W-1:0]  pend_lim;
    logic [ADDR_W-1:0] lo_addr;
    logic [ADDR_W-1:0] hi_addr;
    logic              out_of_range;

    segld_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_req_i      (sel_wr_en_i),
        .range_fault_i (out_of_range),
        .rd_valid_i    (mem_rd_valid_i),
        .ctl_o         (ctl)
    );

    segld_regs #(.SEL_W(SEL_W), .ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_i       (ctl),
        .wr_sel_i    (sel_wr_data_i),
        .gdt_base_i  (gdtr_i[ADDR_W+LIM_W-1:LIM_W]),
        .gdt_lim_i   (gdtr_i[LIM_W-1:0]),
        .rd_data_i   (mem_rd_data_i),
        .pend_sel_o  (pend_sel),
        .pend_base_o (pend_base),
        .pend_lim_o  (pend_lim),
        .sel_o       (sel_o),
        .cache_o     (cache_o),
        .valid_o     (cache_valid_o)
    );

    segld_bounds #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_bounds (
        .index_i        (pend_sel[SEL_W-1:DESC_SHIFT]),
        .tbl_base_i     (pend_base),
        .tbl_lim_i      (pend_lim),
        .lo_addr_o      (lo_addr),
        .hi_addr_o      (hi_addr),
        .out_of_range_o (out_of_range)
    );

    assign mem_rd_en_o   = ctl.rd_en;
    assign mem_rd_addr_o = ctl.rd_hi ? hi_addr : lo_addr;
    assign busy_o        = ctl.busy;
    assign fault_o       = ctl.fault;

endmodule

// File: rtl/segld_chk.sv
module segld_chk #(
    parameter int unsigned SEL_W  = 16,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LIM_W  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sel_wr_en_i,
    input logic                    mem_rd_en_o,
    input logic [SEL_W-1:0]        sel_o,
    input logic [ADDR_W+LIM_W-1:0] cache_o,
    input logic                    cache_valid_o,
    input logic                    busy_o,
    input logic                    fault_o
);
    // R2
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !sel_wr_en_i) |=> !busy_o);

    // R9
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> !mem_rd_en_o);

    // R9
    rd_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |-> busy_o);

    // R7
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> (!fault_o && !busy_o));

    // R7
    fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> ($stable(cache_o) && $stable(sel_o) && $stable(cache_valid_o)));

    // R5
    cache_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_o != $past(cache_o)) |-> $fell(busy_o));

    // R5
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cache_valid_o) |-> $fell(busy_o));

endmodule

bind seg_cache_loader segld_chk #(.SEL_W(SEL_W), .ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_segld_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_wr_en_i   (sel_wr_en_i),
    .mem_rd_en_o   (mem_rd_en_o),
    .sel_o         (sel_o),
    .cache_o       (cache_o),
    .cache_valid_o (cache_valid_o),
    .busy_o        (busy_o),
    .fault_o       (fault_o)
);

// File: tb/tb_seg_cache_loader.sv
module tb_seg_cache_loader;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr_en_i = 1'b0;
    logic [15:0] sel_wr_data_i = '0;
    logic [47:0] gdtr_i = '0;
    logic        mem_rd_en_o;
    logic [31:0] mem_rd_addr_o;
    logic        mem_rd_valid_i = 1'b0;
    logic [31:0] mem_rd_data_i = '0;
    logic [15:0] sel_o;
    logic [47:0] cache_o;
    logic        cache_valid_o;
    logic        busy_o;
    logic        fault_o;

    seg_cache_loader dut (
        .clk(clk), .rst_n(rst_n), .sel_wr_en_i(sel_wr_en_i), .sel_wr_data_i(sel_wr_data_i),
        .gdtr_i(gdtr_i), .mem_rd_en_o(mem_rd_en_o), .mem_rd_addr_o(mem_rd_addr_o),
        .mem_rd_valid_i(mem_rd_valid_i), .mem_rd_data_i(mem_rd_data_i), .sel_o(sel_o),
        .cache_o(cache_o), .cache_valid_o(cache_valid_o), .busy_o(busy_o), .fault_o(fault_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // memory model with variable latency
    logic [31:0] mem [logic [31:0]];
    logic [31:0] rd_log [$];
    int          lat = 1;
    int          cnt = 0;
    logic [31:0] pa  = '0;

    always @(posedge clk) begin
        mem_rd_valid_i <= 1'b0;
        if (mem_rd_en_o) begin
            pa = mem_rd_addr_o;
            cnt = lat;
            rd_log.push_back(mem_rd_addr_o);
        end else if (cnt > 0) begin
            cnt = cnt - 1;
            if (cnt == 0) begin
                mem_rd_valid_i <= 1'b1;
                mem_rd_data_i  <= mem.exists(pa) ? mem[pa] : 32'h0;
            end
        end
    end

    // reference model state
    logic [15:0] m_sel = '0;
    logic [47:0] m_cache = '0;
    logic        m_valid = 1'b0;
    bit          pending = 0;
    bit          p_fault = 0;
    logic [15:0] p_sel;
    logic [31:0] p_lo;
    int          fault_seen;
    int          ncyc;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic compare_idle();
        chk(sel_o == m_sel, "R5 selector", 64'(sel_o), 64'(m_sel));
        chk(cache_o == m_cache, "R5 cache", 64'(cache_o), 64'(m_cache));
        chk(cache_valid_o == m_valid, "R5 valid", 64'(cache_valid_o), 64'(m_valid));
        chk(busy_o == 1'b0, "R2 busy idle", 64'(busy_o), 64'd0);
        chk(fault_o == 1'b0, "R7 fault idle", 64'(fault_o), 64'd0);
        chk(mem_rd_en_o == 1'b0, "R9 read idle", 64'(mem_rd_en_o), 64'd0);
    endtask

    task automatic finish_load();
        pending = 0;
        if (p_fault) begin
            chk(fault_seen == 1, "R7 fault pulse count", 64'(fault_seen), 64'd1);
            chk(rd_log.size() == 0, "R7 no reads on fault", 64'(rd_log.size()), 64'd0);
        end else begin
            chk(fault_seen == 0, "R7 no fault on good load", 64'(fault_seen), 64'd0);
            chk(rd_log.size() == 2, "R9 two reads", 64'(rd_log.size()), 64'd2);
            if (rd_log.size() == 2) begin
                chk(rd_log[0] == p_lo, "R3 low word address", 64'(rd_log[0]), 64'(p_lo));
                chk(rd_log[1] == p_lo + 32'd4, "R3 high word address", 64'(rd_log[1]), 64'(p_lo + 32'd4));
            end
            m_sel   = p_sel;
            m_cache = {(mem.exists(p_lo + 32'd4) ? mem[p_lo + 32'd4] : 32'h0),
                       (mem.exists(p_lo) ? mem[p_lo][15:0] : 16'h0)};
            m_valid = 1'b1;
        end
        rd_log.delete();
    endtask

    task automatic observe();
        if (pending) begin
            if (fault_o) fault_seen++;
            if (!busy_o) begin
                finish_load();
                compare_idle();
            end else begin
                ncyc++;
                if (ncyc > 100) begin
                    chk(1'b0, "R2 load never ends", 64'(busy_o), 64'd0);
                    pending = 0;
                end
            end
        end else begin
            compare_idle();
        end
    endtask

    task automatic do_write(input logic [15:0] s);
        bit acc;
        acc = !pending;
        sel_wr_en_i   = 1'b1;
        sel_wr_data_i = s;
        tick();
        sel_wr_en_i = 1'b0;
        if (acc) begin
            pending    = 1;
            p_sel      = s;
            p_lo       = gdtr_i[47:16] + {16'h0, s[15:3], 3'b000};
            p_fault    = ({1'b0, s[15:3], 3'b000} + 17'd7) > {1'b0, gdtr_i[15:0]};
            fault_seen = 0;
            ncyc       = 0;
            chk(busy_o == 1'b1, "R2 busy after accept", 64'(busy_o), 64'd1);
        end else begin
            observe();
        end
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200 && pending; i++) begin
            tick();
            observe();
        end
        tick();
        observe();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(sel_o == 16'h0, "R1 selector reset", 64'(sel_o), 64'd0);
        chk(cache_o == 48'h0, "R1 cache reset", 64'(cache_o), 64'd0);
        chk(cache_valid_o == 1'b0, "R1 valid reset", 64'(cache_valid_o), 64'd0);
        compare_idle();

        // R7 fault before any load keeps valid low; then R8 index 0 at limit 7
        gdtr_i = {32'h0000_1000, 16'h0007};
        mem[32'h1000] = 32'h0000_0007;
        mem[32'h1004] = 32'h0000_1000;
        do_write(16'h0008);
        wait_done();
        chk(cache_valid_o == 1'b0, "R7 valid stays 0", 64'(cache_valid_o), 64'd0);
        do_write(16'h0000);
        wait_done();
        chk(cache_o == 48'h0000_1000_0007, "R8 index 0 at limit", cache_o, 48'h0000_1000_0007);

        // R4 main example, upper half of low word ignored
        gdtr_i = {32'h0000_2000, 16'h00FF};
        mem[32'h2038] = 32'hDEAD_001F;
        mem[32'h203C] = 32'h0000_2100;
        lat = 1;
        do_write(16'h003B);
        wait_done();
        chk(cache_o == 48'h0000_2100_001F, "R4 cache value", cache_o, 48'h0000_2100_001F);
        chk(sel_o == 16'h003B, "R5 selector commit", 64'(sel_o), 64'h3B);

        // R3 gdtr latched at accept; latency 5
        lat = 5;
        mem[32'h2010] = 32'h0000_0FFF;
        mem[32'h2014] = 32'h0000_0100;
        do_write(16'h0013);
        gdtr_i = {32'h0000_9000, 16'h0000};
        tick(); observe();
        wait_done();
        chk(cache_o == 48'h0000_0100_0FFF, "R3 gdtr latched", cache_o, 48'h0000_0100_0FFF);
        gdtr_i = {32'h0000_2000, 16'h00FF};

        // R6 second write while busy is ignored
        lat = 3;
        mem[32'h2020] = 32'h0000_1234;
        mem[32'h2024] = 32'hABCD_0000;
        mem[32'h2028] = 32'h0000_5555;
        mem[32'h202C] = 32'h6666_0000;
        do_write(16'h0020);
        do_write(16'h0028);
        wait_done();
        chk(sel_o == 16'h0020, "R6 ignored write selector", 64'(sel_o), 64'h20);
        chk(cache_o == 48'hABCD_0000_1234, "R6 ignored write cache", cache_o, 48'hABCD_0000_1234);

        // R8 boundary with flag bits set (R3: low bits do not steer address)
        gdtr_i = {32'h0000_2000, 16'h003F};
        do_write(16'h003F);
        wait_done();
        chk(cache_o == 48'h0000_2100_001F, "R8 boundary load", cache_o, 48'h0000_2100_001F);

        // R7 one past the boundary faults, state kept
        do_write(16'h0040);
        wait_done();
        chk(sel_o == 16'h003F, "R7 selector kept", 64'(sel_o), 64'h3F);
        chk(cache_o == 48'h0000_2100_001F, "R7 cache kept", cache_o, 48'h0000_2100_001F);
        chk(cache_valid_o == 1'b1, "R7 valid kept", 64'(cache_valid_o), 64'd1);

        // R10 same selector again picks up new contents
        mem[32'h203C] = 32'h0BAD_F00D;
        do_write(16'h003F);
        wait_done();
        chk(cache_o == 48'h0BAD_F00D_001F, "R10 reload same selector", cache_o, 48'h0BAD_F00D_001F);

        // R8 highest index against largest limit
        lat = 2;
        gdtr_i = {32'h0000_0000, 16'hFFFF};
        mem[32'h0000_FFF8] = 32'h0000_00AA;
        mem[32'h0000_FFFC] = 32'h1234_5678;
        do_write(16'hFFFB);
        wait_done();
        chk(cache_o == 48'h1234_5678_00AA, "R8 top index", cache_o, 48'h1234_5678_00AA);
        gdtr_i = {32'h0000_0000, 16'hFFFE};
        do_write(16'hFFF8);
        wait_done();
        chk(sel_o == 16'hFFFB, "R7 top index fault", 64'(sel_o), 64'hFFFB);

        repeat (3) begin tick(); observe(); end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule